// File: doc/BRIEF.md
# Batched Power-Register Access Engine

This block sits behind a command mailbox on the controller side. It serves requests aimed at a bank of 8-bit power-management registers. Each request carries a message code, a sub-command, a payload length in bytes and a payload of up to fifteen bytes. The engine checks the request and takes a list of 16-bit register addresses from the payload. It then writes, reads, or does a masked update on an attached register file, touching one register per clock cycle. Read results go into a response buffer. Every request ends with a one-cycle completion strobe, together with an error flag and an error code that stay valid until the next request is accepted.

A single request can reach up to `MAX_REGS` (default five) registers, and those registers need not be next to each other. The payload size depends on the register count. The masked update carries a value byte and a mask byte for one register. The register file is modelled as a plain port with a combinational read and a write taken at the clock edge.

Top module: `pwr_batch_engine`

## Requirements
- R1: A request whose message code is not `MSG_CODE` (default 0xFF) completes with err=1, err_code=1 and no register access.
- R2: With a valid message code, a sub-command other than 0 (write), 1 (read) or 2 (masked update) completes with err=1, err_code=2 and no register access.
- R3: With a valid code and sub-command, a length that fits no register count from 1 to MAX_REGS completes with err=1, err_code=3 and no register access. The legal lengths are 3N for write, 2N for read and exactly 4 for update. A zero length, an odd read length and a length that implies more than MAX_REGS registers are all illegal. The message code is checked first, then the sub-command, then the length.
- R4: Write of N registers: address i sits in payload bytes 2i (low) and 2i+1 (high), with byte 0 in payload bits 7:0. Data byte i sits in payload byte 2N+i. The N writes happen one per cycle, in list order.
- R5: Read of N registers: the registers are read one per cycle, in list order. Result i is placed in resp_data bits 8i+7:8i, and unused response bytes are zero.
- R6: Masked update: the address is in bytes 0–1, the value in byte 2 and the mask in byte 3. The register becomes (old & ~mask) | (value & mask), in a single access cycle.
- R7: done is high for exactly one cycle. For a rejected request it comes right after the accepting clock edge. For a valid N-register request it comes N edges after the accepting edge. busy is high from the accepting edge until done falls.
- R8: A start pulse while busy is high is ignored.
- R9: After reset, done, busy, err, err_code, resp_data, rf_we and rf_re are all zero.
- R10: A successful request reports err=0 and err_code=0. The status and the response are held until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when idle |
| msg_code | input | 8 | Message code of the request |
| sub_cmd | input | 4 | Sub-command: 0 write, 1 read, 2 masked update |
| pay_len | input | 8 | Payload size in bytes |
| payload | input | 3*MAX_REGS*8 | Payload bytes, byte 0 in the low bits |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Error flag of the last request |
| err_code | output | 8 | 0 ok, 1 bad message, 2 bad sub-command, 3 bad length |
| resp_data | output | MAX_REGS*8 | Read results, result 0 in the low byte |
| rf_addr | output | 16 | Register file address |
| rf_re | output | 1 | Register file read in this cycle |
| rf_we | output | 1 | Register file write at the next edge |
| rf_wdata | output | 8 | Register file write data |
| rf_rdata | input | 8 | Register file read data, combinational |

## Verification
A rejected request raises done right after the edge that accepts it. A valid request with N registers raises done after N further edges, because each access takes one cycle. The bench drives start at a falling edge and then counts falling edges until done appears. It compares that count with the latency expected for the vector, and checks one falling edge later that done has already dropped. The register-file model logs every access at the rising edge. Status, response bytes, the access order and the whole register image are all compared only after done, once the last write has landed.

// File: rtl/pwr_batch_engine.sv
module pwr_batch_engine #(
  parameter int          MAX_REGS = 5,
  parameter logic [7:0]  MSG_CODE = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [7:0]                msg_code,
  input  logic [3:0]                sub_cmd,
  input  logic [7:0]                pay_len,
  input  logic [3*MAX_REGS*8-1:0]   payload,
  output logic                      busy,
  output logic                      done,
  output logic                      err,
  output logic [7:0]                err_code,
  output logic [MAX_REGS*8-1:0]     resp_data,
  output logic [15:0]               rf_addr,
  output logic                      rf_re,
  output logic                      rf_we,
  output logic [7:0]                rf_wdata,
  input  logic [7:0]                rf_rdata
);
  localparam int PB = 3 * MAX_REGS;
  localparam int CW = $clog2(MAX_REGS + 1);
  localparam logic [7:0] E_NONE = 8'd0, E_MSG = 8'd1, E_SUB = 8'd2, E_LEN = 8'd3;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_UPD = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t              st;
  logic [PB*8-1:0]  pay;
  logic [1:0]       op;
  logic [CW-1:0]    cnt, idx;
  logic             err_q;
  logic [7:0]       code_q;

  logic             len_ok;
  logic [CW-1:0]    n_val;
  logic [7:0]       chk_code;

  always_comb begin
    len_ok = 1'b0;
    n_val  = '0;
    for (int k = 1; k <= MAX_REGS; k++) begin
      if (sub_cmd == 4'd0 && pay_len == 8'(3 * k)) begin
        len_ok = 1'b1;
        n_val  = CW'(k);
      end
      if (sub_cmd == 4'd1 && pay_len == 8'(2 * k)) begin
        len_ok = 1'b1;
        n_val  = CW'(k);
      end
    end
    if (sub_cmd == 4'd2 && pay_len == 8'd4) begin
      len_ok = 1'b1;
      n_val  = CW'(1);
    end
    if (msg_code != MSG_CODE)   chk_code = E_MSG;
    else if (sub_cmd > 4'd2)    chk_code = E_SUB;
    else if (!len_ok)           chk_code = E_LEN;
    else                        chk_code = E_NONE;
  end

  logic        run;
  logic [7:0]  wr_byte, upd_val, upd_mask;

  assign run      = (st == S_RUN);
  assign rf_addr  = run ? pay[int'(idx)*16 +: 16] : 16'd0;
  assign wr_byte  = pay[(2*int'(cnt) + int'(idx))*8 +: 8];
  assign upd_val  = pay[23:16];
  assign upd_mask = pay[31:24];
  assign rf_we    = run && (op != OP_RD);
  assign rf_re    = run && (op != OP_WR);
  assign rf_wdata = (op == OP_UPD) ? ((rf_rdata & ~upd_mask) | (upd_val & upd_mask)) : wr_byte;

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign err      = err_q;
  assign err_code = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pay       <= '0;
      op        <= OP_WR;
      cnt       <= '0;
      idx       <= '0;
      err_q     <= 1'b0;
      code_q    <= E_NONE;
      resp_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          resp_data <= '0;
          err_q     <= (chk_code != E_NONE);
          code_q    <= chk_code;
          idx       <= '0;
          if (chk_code != E_NONE) begin
            st <= S_FIN;
          end else begin
            st  <= S_RUN;
            pay <= payload;
            op  <= sub_cmd[1:0];
            cnt <= n_val;
          end
        end
        S_RUN: begin
          if (op == OP_RD) resp_data[int'(idx)*8 +: 8] <= rf_rdata;
          if (idx == cnt - CW'(1)) st <= S_FIN;
          else                     idx <= idx + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R1 R2 R3
  rejected_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($past(st) == S_IDLE));

  // R10
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (err_code != E_NONE)));

  // R4 R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (idx < cnt) && (cnt != '0));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cnt) && $stable(op));

  // R6
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_UPD) |=> done);
endmodule

// File: tb/pwr_batch_engine_test.sv
`timescale 1ns/1ps
module pwr_batch_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         start = 1'b0;
  logic [7:0]   msg_i = 8'h00;
  logic [3:0]   sub_i = 4'h0;
  logic [7:0]   len_i = 8'h00;
  logic [119:0] pay_i = '0;
  logic         busy, done, err;
  logic [7:0]   err_code;
  logic [39:0]  resp;
  logic [15:0]  rf_addr;
  logic         rf_re, rf_we;
  logic [7:0]   rf_wdata, rf_rdata;

  pwr_batch_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_code(msg_i), .sub_cmd(sub_i),
    .pay_len(len_i), .payload(pay_i), .busy(busy), .done(done), .err(err),
    .err_code(err_code), .resp_data(resp), .rf_addr(rf_addr), .rf_re(rf_re),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  logic [7:0]  mem [0:255];
  logic [7:0]  ref_mem [0:255];
  logic [15:0] log_a [0:1023];
  int          log_n = 0;
  int          total = 0;
  int          bad = 0;

  assign rf_rdata = mem[rf_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (rf_we) mem[rf_addr[7:0]] <= rf_wdata;
      if (rf_we || rf_re) begin
        log_a[log_n] = rf_addr;
        log_n = log_n + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]   msg;
    logic [3:0]   sub;
    logic [7:0]   len;
    logic [119:0] pay;
    logic [7:0]   code;
    logic [7:0]   lat;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{8'hFF, 4'd0, 8'd3,  120'hA50010, 8'd0, 8'd1},
    '{8'hFF, 4'd0, 8'd9,  120'h332211_0030_0105_0020, 8'd0, 8'd3},
    '{8'hFF, 4'd1, 8'd4,  120'h0020_0010, 8'd0, 8'd2},
    '{8'hFF, 4'd1, 8'd10, 120'h0010_0002_0001_0105_0030, 8'd0, 8'd5},
    '{8'hFF, 4'd2, 8'd4,  120'h3CF00030, 8'd0, 8'd1},
    '{8'hFF, 4'd0, 8'd15, 120'h5453525150_0044_0043_0042_0041_0040, 8'd0, 8'd5},
    '{8'hF8, 4'd1, 8'd2,  120'h0010, 8'd1, 8'd0},
    '{8'hFF, 4'd3, 8'd3,  120'h770010, 8'd2, 8'd0},
    '{8'hFF, 4'd0, 8'd0,  120'h770010, 8'd3, 8'd0},
    '{8'hFF, 4'd0, 8'd18, 120'h770010, 8'd3, 8'd0},
    '{8'hFF, 4'd1, 8'd3,  120'h0010, 8'd3, 8'd0},
    '{8'hFF, 4'd2, 8'd3,  120'h3CF00030, 8'd3, 8'd0},
    '{8'hFF, 4'd1, 8'd12, 120'h0010, 8'd3, 8'd0}
  };

  function automatic string req_of(input vec_t v);
    if (v.code == 8'd1) return "R1";
    if (v.code == 8'd2) return "R2";
    if (v.code == 8'd3) return "R3";
    if (v.sub == 4'd0)  return "R4";
    if (v.sub == 4'd1)  return "R5";
    return "R6";
  endfunction

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input vec_t v, input int base, input int lat);
    string r;
    int n, nacc, mism;
    logic [39:0] eresp;
    logic [7:0] a;
    r = req_of(v);
    n = int'(v.lat);
    nacc = log_n - base;
    eresp = '0;
    chk(lat == n, {r, " R7 latency"}, 64'(lat), 64'(n));
    chk(err == (v.code != 0), {r, " err"}, 64'(err), 64'(v.code != 0));
    chk(err_code == v.code, {r, " err_code"}, 64'(err_code), 64'(v.code));
    chk(nacc == ((v.code == 0) ? n : 0), {r, " access count"}, 64'(nacc), 64'((v.code == 0) ? n : 0));
    if (v.code == 0) begin
      for (int i = 0; i < n; i++) begin
        chk(log_a[base + i] == v.pay[16*i +: 16], {r, " access order"}, 64'(log_a[base + i]), 64'(v.pay[16*i +: 16]));
        a = v.pay[16*i +: 8];
        if (v.sub == 4'd0) ref_mem[a] = v.pay[(2*n + i)*8 +: 8];
        if (v.sub == 4'd1) eresp[8*i +: 8] = ref_mem[a];
        if (v.sub == 4'd2) ref_mem[a] = (ref_mem[a] & ~v.pay[31:24]) | (v.pay[23:16] & v.pay[31:24]);
      end
    end
    chk(resp == eresp, {r, " resp_data"}, 64'(resp), 64'(eresp));
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mism++;
    chk(mism == 0, {r, " register image"}, 64'(mism), 64'd0);
  endtask

  task automatic run_vec(input vec_t v);
    int base, lat;
    base = log_n;
    @(negedge clk);
    msg_i = v.msg; sub_i = v.sub; len_i = v.len; pay_i = v.pay; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check_result(v, base, lat);
    @(negedge clk);
    chk(!done, "R7 done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    int base, lat;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(!done && !busy && !err && err_code == 0, "R9 status after reset", {busy, done, err, err_code}, 64'd0);
    chk(resp == 0 && !rf_we && !rf_re, "R9 resp and port after reset", 64'(resp), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !rf_we && !rf_re, "R9 idle after release", {busy, done, rf_we, rf_re}, 64'd0);

    for (int k = 0; k < 13; k++) run_vec(VEC[k]);

    // R10: status of a rejected request held while idle
    repeat (3) @(negedge clk);
    chk(err && err_code == 8'd3, "R10 held status", {err, err_code}, {1'b1, 8'd3});

    // R8: start pulses while busy are ignored
    v = '{8'hFF, 4'd0, 8'd15, 120'h6463626160_0044_0043_0042_0041_0040, 8'd0, 8'd5};
    base = log_n;
    @(negedge clk);
    msg_i = v.msg; sub_i = v.sub; len_i = v.len; pay_i = v.pay; start = 1'b1;
    @(negedge clk);
    chk(busy, "R7 busy after accept", 64'(busy), 64'd1);
    msg_i = 8'hF8; sub_i = 4'd1; len_i = 8'd2; pay_i = 120'h0010;
    lat = 0;
    repeat (2) begin
      if (!done) begin
        @(negedge clk);
        lat++;
      end
    end
    start = 1'b0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check_result(v, base, lat);
    repeat (4) begin
      @(negedge clk);
      chk(!done && !busy, "R8 no second request", {done, busy}, 64'd0);
    end
    chk(log_n - base == 5, "R8 access count", 64'(log_n - base), 64'd5);

    // R10: success status and response held until the next start
    run_vec(VEC[2]);
    repeat (3) @(negedge clk);
    chk(!err && err_code == 0, "R10 success held", {err, err_code}, 64'd0);
    chk(resp == {24'd0, ref_mem[8'h20], ref_mem[8'h10]}, "R10 resp held", 64'(resp), 64'({24'd0, ref_mem[8'h20], ref_mem[8'h10]}));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule